// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Access Controller

This block puts a small behavioural memory array behind the command timing of a synchronous burst SRAM. On every rising clock edge it samples one command: a read, a write or a deselect. The caller supplies the address one word at a time, usually from an address sequencer. A write stores any chosen subset of four 9-bit byte lanes in the 36-bit word, or all of them when the global-write input is high. A read returns the addressed word on the data output together with a drive flag. The flag stands in for the tri-state enable of the data pins.

A static mode input chooses between two read paths. In flow-through mode the read word goes straight from the array to the output. In pipeline mode it passes through a rising-edge output register, which adds one cycle of latency. A deselect or a write cycle turns the drive flag off after the same delay that a read would take to turn it on, so the turn-off is pipelined as deeply as the read data. The output enable gates the drive flag without waiting for a clock edge. The sleep input stops all commands and turns the outputs off while keeping the array contents.

Top module: `sram_access_ctl`

## Requirements
- R1: A clock edge with `rst_n` low clears both read stages, so after reset `dq_drive` is 0 and `dq_out` is 0 until a read is accepted.
- R2: With `pipe_mode` = 0 (flow-through), a read sampled at edge E makes `dq_drive` = 1 and `dq_out` = the addressed word in the cycle between E and E+1.
- R3: With `pipe_mode` = 1 (pipeline), a read sampled at edge E makes `dq_drive` = 1 and `dq_out` = the addressed word in the cycle between E+1 and E+2, which is one cycle later than in flow-through mode.
- R4: Reads on consecutive edges return one word per cycle, in command order, in both modes.
- R5: A cycle with `ce` = 1, `gw` = 0 and `bwe` = 1 writes lane i (`wr_data[9i+8:9i]`) only where `lane_strb[i]` = 1. Unstrobed lanes keep their old value.
- R6: A cycle with `ce` = 1 and `gw` = 1 writes all four lanes, whatever `bwe` and `lane_strb` are.
- R7: A cycle with `ce` = 1, `gw` = 0, `bwe` = 1 and `lane_strb` = 0 is a write cycle that changes no byte and does not drive the outputs.
- R8: A deselect (`ce` = 0) or a write cycle sampled at edge E turns `dq_drive` off at the same point where a read sampled at E would turn it on: from E in flow-through mode and from E+1 in pipeline mode.
- R9: `out_en` = 0 forces `dq_drive` and `dq_out` to 0 at once, with no clock edge needed. Raising it again restores the pending read output.
- R10: While `sleep` = 1 the outputs are off, commands are ignored, both read stages are flushed and the array keeps its contents.
- R11: `dq_out` is 0 whenever `dq_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Chip enable; low marks a deselect cycle |
| addr | input | ADDR_W (6) | Word address of the command |
| wr_data | input | LANES*LANE_W (36) | Write data, lane i in bits 9i+8:9i |
| lane_strb | input | LANES (4) | Per-lane write strobes, used when `bwe` is high |
| bwe | input | 1 | Byte-write enable |
| gw | input | 1 | Global write of all lanes |
| pipe_mode | input | 1 | 1 = registered (pipeline) reads, 0 = flow-through reads |
| out_en | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Low-power request; blocks commands and turns the outputs off |
| dq_out | output | LANES*LANE_W (36) | Read data; zero when not driven |
| dq_drive | output | 1 | Output drive enable for the data pins |

## Verification
The hardest case to reach is a turn-off caught in the middle of the pipeline. A deselect or write must follow a read on the very next edge, and in pipeline mode the read word must still be leaving the output register while the new command is already in the first stage. The stimulus builds read, deselect, read, write, read streams in both modes. It also raises sleep and drops the output enable halfway through a read stream, so that the flush and the asynchronous gate both act on a stage that holds a live word. A behavioural model keeps its own history of accepted commands. Every cycle the outputs are compared with the entry from one command back or two commands back, depending on the mode.

// File: rtl/sram_ctl_pkg.sv
// Package: shared command encoding for the SRAM access controller.
// Assumes: one command per clock, decoded before any state is updated.
package sram_ctl_pkg;

    // Command class seen by the array and the read stages.
    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2
    } cmd_e;

endpackage

// File: rtl/sram_cmd_dec.sv
// Module: sram_cmd_dec
// Sorts the sampled control inputs into nop, read or write, and builds the
// per-lane write mask. Global write wins over the byte-write controls. A
// byte-write with no strobes is still a write cycle (the outputs stay off).
// Assumes: 'accept' is low during reset and sleep; no command is taken then.
module sram_cmd_dec
    import sram_ctl_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             accept,
    input  logic             ce,
    input  logic             bwe,
    input  logic             gw,
    input  logic [LANES-1:0] strb,
    output cmd_e             cmd,
    output logic [LANES-1:0] wr_mask
);

    // Decode the command class and the lane mask.
    always_comb begin
        cmd     = CMD_NOP;
        wr_mask = '0;
        if (accept && ce) begin
            if (gw) begin
                cmd     = CMD_WR;
                wr_mask = '1;
            end else if (bwe) begin
                cmd     = CMD_WR;
                wr_mask = strb;
            end else begin
                cmd     = CMD_RD;
            end
        end
    end

endmodule

// File: rtl/sram_lane_array.sv
// Module: sram_lane_array
// Behavioural storage split into independent byte lanes. Each lane has its
// own write enable and is read combinationally at a separate read address.
// Assumes: the contents are not reset (contents survive reset and sleep).
module sram_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Store this lane when its mask bit is set.
        always_ff @(posedge clk) begin
            if (wr_mask[g]) begin
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end

endmodule

// File: rtl/sram_rd_pipe.sv
// Module: sram_rd_pipe
// Two read stages. Stage 1 holds the accepted command and address and feeds
// the array read port. Stage 2 is the output register. The mode picks stage
// 1 (flow-through) or stage 2 (pipeline) as the output source. Deselects and
// writes travel down the same stages as reads, so the turn-off has the same
// latency as the turn-on.
// Assumes: 'flush' (sleep) empties both stages and gates the output at once.
module sram_rd_pipe #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              pipe_mode,
    input  logic              out_en,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [DATA_W-1:0] arr_data,
    output logic              dq_drive,
    output logic [DATA_W-1:0] dq_out
);

    logic              s1_rd;
    logic [ADDR_W-1:0] s1_addr;
    logic              s2_rd;
    logic [DATA_W-1:0] s2_data;
    logic              sel_rd;
    logic [DATA_W-1:0] sel_data;

    // Stage 1: capture the command class and address.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            s1_rd   <= 1'b0;
            s1_addr <= '0;
        end else begin
            s1_rd   <= rd_req;
            s1_addr <= req_addr;
        end
    end

    // Stage 2: output register fed from the array read port.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            s2_rd   <= 1'b0;
            s2_data <= '0;
        end else begin
            s2_rd   <= s1_rd;
            s2_data <= arr_data;
        end
    end

    assign arr_addr = s1_addr;

    // Output source selection and asynchronous gating.
    always_comb begin
        sel_rd   = pipe_mode ? s2_rd   : s1_rd;
        sel_data = pipe_mode ? s2_data : arr_data;
        dq_drive = sel_rd && out_en && !flush;
        dq_out   = dq_drive ? sel_data : '0;
    end

endmodule

// File: rtl/sram_access_ctl.sv
// Module: sram_access_ctl (top)
// Synchronous SRAM access controller: command decode, lane-split array and
// a two-stage read path with selectable flow-through or pipeline output.
// Writes happen at the edge that samples them. Reads see all earlier writes.
// Assumes: pipe_mode changes only while the read path is idle.
module sram_access_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [LANES-1:0]        lane_strb,
    input  logic                    bwe,
    input  logic                    gw,
    input  logic                    pipe_mode,
    input  logic                    out_en,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_drive
);

    localparam int DATA_W = LANES * LANE_W;

    cmd_e              cmd;
    logic [LANES-1:0]  wr_mask;
    logic [ADDR_W-1:0] arr_addr;
    logic [DATA_W-1:0] arr_data;
    logic              accept;

    assign accept = rst_n && !sleep;

    sram_cmd_dec #(.LANES(LANES)) dec_i (
        .accept  (accept),
        .ce      (ce),
        .bwe     (bwe),
        .gw      (gw),
        .strb    (lane_strb),
        .cmd     (cmd),
        .wr_mask (wr_mask)
    );

    sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) arr_i (
        .clk     (clk),
        .wr_addr (addr),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .rd_addr (arr_addr),
        .rd_data (arr_data)
    );

    sram_rd_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rdp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (sleep),
        .rd_req    (cmd == CMD_RD),
        .req_addr  (addr),
        .pipe_mode (pipe_mode),
        .out_en    (out_en),
        .arr_addr  (arr_addr),
        .arr_data  (arr_data),
        .dq_drive  (dq_drive),
        .dq_out    (dq_out)
    );

    // R9
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !dq_drive);

    // R10
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!dq_drive && wr_mask == '0));

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_drive |-> dq_out == '0);

    // R6
    gw_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && gw && !sleep) |-> (wr_mask == '1 && cmd == CMD_WR));

    // R7
    empty_bw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && bwe && !gw && lane_strb == '0 && !sleep) |-> (cmd == CMD_WR && wr_mask == '0));

    // R5
    bw_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && bwe && !gw && !sleep) |-> wr_mask == lane_strb);

endmodule

// File: tb/sram_access_ctl_tb.sv
`timescale 1ns/1ps
module sram_access_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0;
    logic [5:0]  addr = '0;
    logic [35:0] wr_data = '0;
    logic [3:0]  lane_strb = '0;
    logic        bwe = 1'b0;
    logic        gw = 1'b0;
    logic        pipe_mode = 1'b0;
    logic        out_en = 1'b1;
    logic        sleep = 1'b0;
    logic [35:0] dq_out;
    logic        dq_drive;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    string req_tag = "R1";

    always #2.5 clk = ~clk;

    sram_access_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .ce(ce), .addr(addr), .wr_data(wr_data),
        .lane_strb(lane_strb), .bwe(bwe), .gw(gw), .pipe_mode(pipe_mode),
        .out_en(out_en), .sleep(sleep), .dq_out(dq_out), .dq_drive(dq_drive)
    );

    // Reference model: memory image plus a history of accepted commands.
    logic [35:0] mm [64];
    bit          hq[$];
    logic [35:0] dq[$];
    bit          m_r;
    logic [35:0] m_v;

    always @(posedge clk) begin
        if (!rst_n || sleep) begin
            hq = '{1'b0, 1'b0};
            dq = '{36'd0, 36'd0};
        end else begin
            m_r = 1'b0;
            m_v = '0;
            if (ce) begin
                if (gw) mm[addr] = wr_data;
                else if (bwe) begin
                    for (int i = 0; i < 4; i++)
                        if (lane_strb[i]) mm[addr][9*i +: 9] = wr_data[9*i +: 9];
                end else begin
                    m_r = 1'b1;
                    m_v = mm[addr];
                end
            end
            hq.push_front(m_r);
            dq.push_front(m_v);
            while (hq.size() > 2) begin
                void'(hq.pop_back());
                void'(dq.pop_back());
            end
        end
    end

    task automatic check(input string what, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", req_tag, what, act, exp);
        end
    endtask

    task automatic compare();
        bit          e_rd;
        bit          e_drv;
        logic [35:0] e_dat;
        e_rd  = pipe_mode ? hq[1] : hq[0];
        e_drv = e_rd && out_en && !sleep;
        e_dat = e_drv ? (pipe_mode ? dq[1] : dq[0]) : 36'd0;
        check("dq_drive", {35'd0, dq_drive}, {35'd0, e_drv});
        check("dq_out", dq_out, e_dat);
    endtask

    task automatic step(input bit c, input logic [5:0] a, input logic [35:0] d,
                        input logic [3:0] s, input bit b, input bit g);
        @(negedge clk);
        compare();
        ce = c; addr = a; wr_data = d; lane_strb = s; bwe = b; gw = g;
    endtask

    task automatic rd(input logic [5:0] a);
        step(1'b1, a, 36'd0, 4'd0, 1'b0, 1'b0);
    endtask

    task automatic idle();
        step(1'b0, 6'd0, 36'd0, 4'd0, 1'b0, 1'b0);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        finish_up();
    end

    initial begin
        hq = '{1'b0, 1'b0};
        dq = '{36'd0, 36'd0};
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("reset drive", {35'd0, dq_drive}, 36'd0);
        check("reset data", dq_out, 36'd0);
        rst_n = 1'b1;

        // R6: global write fills the array with bwe and strobes set as noise
        req_tag = "R6";
        for (int a = 0; a < 64; a++)
            step(1'b1, 6'(a), 36'(a) * 36'h0_0402_0101 + 36'h9_8765_4321, 4'b0101, 1'b1, 1'b1);
        idle();

        // R2: flow-through single reads and a back-to-back stream
        req_tag = "R2";
        pipe_mode = 1'b0;
        rd(6'd3); idle(); idle(); rd(6'd17); idle(); idle();
        req_tag = "R4";
        for (int a = 20; a < 28; a++) rd(6'(a));
        idle(); idle();

        // R3: pipeline single reads and a back-to-back stream
        req_tag = "R3";
        pipe_mode = 1'b1;
        idle(); rd(6'd5); idle(); idle(); idle(); rd(6'd63); idle(); idle();
        req_tag = "R4";
        for (int a = 40; a < 50; a++) rd(6'(a));
        idle(); idle(); idle();

        // R5: byte writes with several strobe patterns, read back in both modes
        req_tag = "R5";
        step(1'b1, 6'd10, 36'hA_AAAA_AAAA, 4'b0001, 1'b1, 1'b0);
        step(1'b1, 6'd11, 36'h5_5555_5555, 4'b1010, 1'b1, 1'b0);
        step(1'b1, 6'd12, 36'hF_0F0F_0F0F, 4'b1100, 1'b1, 1'b0);
        step(1'b1, 6'd13, 36'h1_2345_6789, 4'b1111, 1'b1, 1'b0);
        rd(6'd10); rd(6'd11); rd(6'd12); rd(6'd13); idle(); idle(); idle();
        pipe_mode = 1'b0;
        idle(); rd(6'd10); rd(6'd11); rd(6'd12); idle(); idle();

        // R7: byte-write enable with no strobes changes nothing
        req_tag = "R7";
        step(1'b1, 6'd30, 36'hF_FFFF_FFFF, 4'b0000, 1'b1, 1'b0);
        rd(6'd30); idle(); idle();

        // R8: deselect and write turn-off in both modes
        req_tag = "R8";
        rd(6'd1); idle(); rd(6'd2); step(1'b1, 6'd33, 36'h0_1111_2222, 4'b0011, 1'b1, 1'b0);
        rd(6'd33); rd(6'd34); idle(); idle();
        pipe_mode = 1'b1;
        idle(); idle();
        rd(6'd1); idle(); rd(6'd2); step(1'b1, 6'd35, 36'h3_3333_4444, 4'b0110, 1'b1, 1'b0);
        rd(6'd35); rd(6'd36); idle(); idle(); idle();

        // R9: asynchronous output enable on a live word in flow-through mode
        req_tag = "R9";
        pipe_mode = 1'b0;
        idle(); rd(6'd8);
        @(negedge clk);
        compare();
        out_en = 1'b0;
        #1;
        check("oe low drive", {35'd0, dq_drive}, 36'd0);
        check("oe low data", dq_out, 36'd0);
        out_en = 1'b1;
        #1;
        check("oe high drive", {35'd0, dq_drive}, 36'd1);
        check("oe high data", dq_out, mm[8]);
        idle(); idle();
        out_en = 1'b0;
        rd(6'd9); rd(6'd9); idle();
        out_en = 1'b1;
        idle();

        // R10: sleep flushes a pipeline stream, blocks writes, keeps contents
        req_tag = "R10";
        pipe_mode = 1'b1;
        rd(6'd50); rd(6'd51); rd(6'd52);
        sleep = 1'b1;
        step(1'b1, 6'd50, 36'h0, 4'b1111, 1'b1, 1'b1);
        step(1'b1, 6'd51, 36'h0, 4'b1111, 1'b1, 1'b0);
        rd(6'd52); idle();
        sleep = 1'b0;
        idle(); rd(6'd50); rd(6'd51); rd(6'd52); idle(); idle(); idle();

        // R11: data stays zero while idle after traffic
        req_tag = "R11";
        idle(); idle(); idle();

        // R1: reset in the middle of a stream clears both stages
        req_tag = "R1";
        rd(6'd4); rd(6'd5);
        rst_n = 1'b0;
        idle();
        @(negedge clk);
        check("mid reset drive", {35'd0, dq_drive}, 36'd0);
        rst_n = 1'b1;
        idle(); idle();
        finish_up();
    end

endmodule